// File: doc/BRIEF.md
# Status-Overridable LED and Switch Register Block

This block sits on an APB bus and drives a row of eight LEDs. In its normal mode the LEDs copy a software-written LED register. When software sets a source-select bit, the LEDs show eight processor status lines instead. Each status line passes through its own pulse stretcher, so an event that lasts one clock cycle still produces a visible flash.

The block also gives software a read-only view of eight DIP switch inputs. Each switch input passes through a two-flop synchronizer before software can read it. The LED register keeps its contents while the status view is selected. Clearing the select bit returns the stored pattern to the LEDs.

Top module: `led_status_ctrl`

## Requirements
- R1: After reset, the LED register, the source-select bit and every stretch counter are zero, so `led_out` reads 0x00.
- R2: The LED register sits at byte offset 0x0 and is 8 bits wide. A read returns the last value written in bits 7:0 and zero in bits 31:8.
- R3: While the source-select bit is 0, `led_out` equals the LED register. A new written value appears at `led_out` at the rising edge that completes the write. A 1 in a bit lights that LED.
- R4: The source-select bit is bit 0 at byte offset 0x4. Writing 1 selects the status view and writing 0 selects the LED register. A read returns the bit in bit 0 and zero in bits 31:1.
- R5: In the status view, `led_out[k]` follows `cpu_stat[k]`. The bits carry, from 7 down to 0: sleeping, deep sleep, halted, lockup, reset request, event out, wakeup, debug restarted.
- R6: Every rising edge at which a status bit is high reloads that bit's counter to 2^STRETCH_W-1. The LED is on from the edge after the input is first seen high until the counter expires, that is exactly 2^STRETCH_W-1 cycles after the last edge that sampled the input high.
- R7: The switch register sits at byte offset 0x8. It returns the synchronized `sw_in` in bits 7:0 and zero in bits 31:8. A change on `sw_in` is visible to a read two rising edges after the change.
- R8: Writes to the LED register while the status view is active are stored and read back, but they do not change `led_out`. The stored value appears at `led_out` once the select bit is cleared.
- R9: Reads of unmapped offsets return zero, and writes to them change no register. `pready` is always 1, so there are no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| cpu_stat | input | N | Processor status lines |
| sw_in | input | N | DIP switch inputs |
| led_out | output | N | LED drive, 1 lights |

## Verification
A wrong source-select bit or a corrupted LED register shows on `led_out` at the edge that completes the faulty write, because the output mux has no further stage. A stretch counter that is loaded or decremented wrongly shows up as a flash that ends early or late; the bench can see this only by counting cycles until the LED drops. A missing or extra synchronizer stage shifts the switch read by one edge, so the bench reads the switches both one edge and two edges after a change.

// File: rtl/led_status_ctrl.sv
module led_status_ctrl #(
  parameter int N         = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int STRETCH_W = 20
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic [N-1:0]      cpu_stat,
  input  logic [N-1:0]      sw_in,
  output logic [N-1:0]      led_out
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_LED  = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_MODE = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_SW   = WORD_W'(2);
  localparam logic [STRETCH_W-1:0] CNT_MAX = {STRETCH_W{1'b1}};

  logic [N-1:0] led_q, sw_meta, sw_sync, stretched;
  logic         mode_q;
  logic [WORD_W-1:0] word;
  logic         wr_en;

  assign word   = paddr[ADDR_W-1:2];
  assign wr_en  = psel & penable & pwrite;
  assign pready = 1'b1;

  logic unused_bits;
  assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:N]};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      led_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      if (word == W_LED)  led_q  <= pwdata[N-1:0];
      if (word == W_MODE) mode_q <= pwdata[0];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sw_meta <= '0;
      sw_sync <= '0;
    end else begin
      sw_meta <= sw_in;
      sw_sync <= sw_meta;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_stretch
    logic [STRETCH_W-1:0] cnt;
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)         cnt <= '0;
      else if (cpu_stat[k]) cnt <= CNT_MAX;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign stretched[k] = (cnt != '0);
  end

  assign led_out = mode_q ? stretched : led_q;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (word)
        W_LED:   prdata[N-1:0] = led_q;
        W_MODE:  prdata[0]     = mode_q;
        W_SW:    prdata[N-1:0] = sw_sync;
        default: prdata        = '0;
      endcase
    end
  end

  assert_led_write_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && word == W_LED && !mode_q) |=> (led_out == $past(pwdata[N-1:0])));

  assert_mode_only_by_write_R4: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(mode_q) |-> $past(wr_en && word == W_MODE));

  assert_stretch_catch_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (cpu_stat != '0) |=> ((stretched & $past(cpu_stat)) == $past(cpu_stat)));

  assert_stretch_no_drop_while_high_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (($past(stretched) & ~stretched & $past(cpu_stat)) == '0));

  assert_switch_upper_zero_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && word == W_SW) |-> (prdata[DATA_W-1:N] == '0));

  assert_ready_R9: assert property (@(posedge pclk) disable iff (!presetn) pready);
endmodule

// File: tb/tb_led_status_ctrl.sv
module tb_led_status_ctrl;
  localparam int N = 8, ADDR_W = 12, DATA_W = 32, SW = 4;
  localparam int HOLD = (1 << SW) - 1;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0, prdata;
  logic pready;
  logic [N-1:0] cpu_stat = '0, sw_in = '0, led_out;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 pclk = ~pclk;

  led_status_ctrl #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRETCH_W(SW)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .cpu_stat(cpu_stat), .sw_in(sw_in), .led_out(led_out));

  localparam logic [7:0] VEC [8] = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h3C, 8'hC3};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge pclk);
    check("R1 led_out", led_out, 0);
    check("R9 pready", pready, 1);
    presetn = 1;
    @(negedge pclk);
    apb_read(12'h000, rd); check("R1 led reg", rd, 0);
    apb_read(12'h004, rd); check("R1 mode", rd, 0);

    for (int i = 0; i < 8; i++) begin
      apb_write(12'h000, {24'hDEAD00, VEC[i]});
      check("R3 led_out", led_out, VEC[i]);
      apb_read(12'h000, rd); check("R2 readback", rd, {24'h0, VEC[i]});
    end

    apb_write(12'h000, 32'h3C);
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_read(12'h004, rd); check("R4 mode readback", rd, 1);
    check("R4 status view idle", led_out, 0);

    @(negedge pclk); cpu_stat = 8'h08;
    @(negedge pclk); cpu_stat = 8'h00;
    check("R6 pulse caught", led_out, 8'h08);
    repeat (HOLD - 1) @(negedge pclk);
    check("R6 still on at last cycle", led_out, 8'h08);
    @(negedge pclk);
    check("R6 expired", led_out, 8'h00);

    cpu_stat = 8'hA5;
    @(negedge pclk); cpu_stat = 8'h00;
    check("R5 bit order", led_out, 8'hA5);
    repeat (HOLD + 2) @(negedge pclk);
    check("R6 all expired", led_out, 0);

    cpu_stat = 8'h40;
    repeat (HOLD + 5) @(negedge pclk);
    check("R6 held while high", led_out, 8'h40);
    cpu_stat = 0;
    repeat (HOLD) @(negedge pclk);
    check("R6 expiry after long high", led_out, 0);

    apb_write(12'h000, 32'h81);
    check("R8 write hidden in status view", led_out, 0);
    apb_read(12'h000, rd); check("R8 stored", rd, 32'h81);
    apb_write(12'h004, 32'h0);
    check("R8 restored", led_out, 8'h81);

    sw_in = 8'h5A;
    apb_read(12'h008, rd); check("R7 one edge old", rd, 0);
    apb_read(12'h008, rd); check("R7 synced", rd, 32'h5A);
    sw_in = 8'hFF;
    @(negedge pclk);
    apb_read(12'h008, rd); check("R7 all ones upper zero", rd, 32'hFF);

    apb_write(12'h010, 32'hFFFF_FFFF);
    check("R9 unmapped write no effect", led_out, 8'h81);
    apb_read(12'h000, rd); check("R9 led reg intact", rd, 32'h81);
    apb_read(12'h004, rd); check("R9 mode intact", rd, 0);
    apb_read(12'h010, rd); check("R9 unmapped read", rd, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule